// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two W-bit buses, A and B (W = 8 by default). Each direction has its own storage register with its own clock. The A-to-B register loads from bus A on a rising edge of `clk_ab`. The B-to-A register loads from bus B on a rising edge of `clk_ba`. An active-low enable and a direction input choose which bus the block drives, if any.

A select input for each direction decides what the driven bus carries. With select 0 it carries the live value of the opposite bus. With select 1 it carries the value held in that direction's register. Data can therefore be stored while both sides are isolated, and replayed later onto either side.

The bidirectional pins are split into an input, an output value and an output enable for each bus. The register of a bus loads the value that is actually present on that bus. When the block is driving the bus, that is the driven value.

Top module: `regbus_xcvr`

## Requirements
- R1: An asynchronous low level on `rst_n` clears both storage registers to zero at once. A rising clock edge during reset does not load either register.
- R2: While `oe_n` is 1, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` both read 0.
- R3: While `oe_n` is 0, `dir_a2b` = 1 drives bus B only (`b_oe` = 1, `a_oe` = 0). `dir_a2b` = 0 drives bus A only (`a_oe` = 1, `b_oe` = 0). The two enables are never 1 together, and an output whose enable is 0 reads 0.
- R4: When the driven bus has its select at 0 (`sel_ab` for bus B, `sel_ba` for bus A), it carries the live opposite input bit for bit, with no inversion.
- R5: When the driven bus has its select at 1, it carries that direction's register (A-to-B register on bus B, B-to-A register on bus A).
- R6: A rising edge of `clk_ab` loads the A-to-B register from bus A. A rising edge of `clk_ba` loads the B-to-A register from bus B. This holds in every mode, including isolation and while the other bus is driven.
- R7: When a bus is driven by the block at the moment its register's clock rises, the register loads the driven value (`a_out` or `b_out`), not the input pin.
- R8: An edge on one clock leaves the other direction's register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Load clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Load clock of the B-to-A register (rising edge) |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir_a2b | input | 1 | 1: bus B is driven; 0: bus A is driven |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B register |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A register |
| a_in | input | W | Value seen on bus A pins |
| b_in | input | W | Value seen on bus B pins |
| a_out | output | W | Value driven onto bus A (0 when not driven) |
| a_oe | output | 1 | Bus A driver enable |
| b_out | output | W | Value driven onto bus B (0 when not driven) |
| b_oe | output | 1 | Bus B driver enable |

## Verification
The bench sweeps all sixteen combinations of enable, direction and the two selects. Each combination is tried under six data patterns, among them all-zero, all-one, alternating and single-bit values. The two buses always carry different values, so a swapped source, an inverted bit or a live-versus-stored mix-up shows up as a mismatch.

In every combination both clocks are pulsed in turn. Both registers are then read back through the outputs. This separates loading from the input pin from loading from the driven value, and it separates loading from leaving a register alone. A closing step pulses only one clock, to confirm that the other register is left alone. Resets early in the run and in the middle of it confirm that stored data is cleared.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic a_en;
    logic b_en;
  } drive_t;

  function automatic drive_t xcvr_decode(input logic oe_n, input logic dir_a2b);
    drive_t d;
    d.a_en = 1'b0;
    d.b_en = 1'b0;
    if (!oe_n) begin
      if (dir_a2b) d.b_en = 1'b1;
      else         d.a_en = 1'b1;
    end
    return d;
  endfunction

  typedef enum logic {SRC_LIVE = 1'b0, SRC_STORED = 1'b1} src_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir_a2b,
  output logic a_en,
  output logic b_en
);
  drive_t drv;

  always_comb begin
    drv  = xcvr_decode(oe_n, dir_a2b);
    a_en = drv.a_en;
    b_en = drv.b_en;
  end
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout
);
  src_t src;

  always_comb begin
    src  = src_t'(sel);
    dout = '0;
    if (en) begin
      for (int i = 0; i < W; i++) begin
        dout[i] = (src == SRC_STORED) ? stored[i] : live[i];
      end
    end
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         oe_n,
  input  logic         dir_a2b,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic         drv_a_en;
  logic         drv_b_en;
  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;
  logic [W-1:0] bus_a_eff;
  logic [W-1:0] bus_b_eff;
  logic [W-1:0] a_drive;
  logic [W-1:0] b_drive;

  xcvr_ctrl u_ctrl (
    .oe_n    (oe_n),
    .dir_a2b (dir_a2b),
    .a_en    (drv_a_en),
    .b_en    (drv_b_en)
  );

  xcvr_path #(.W(W)) u_path_b (
    .en     (drv_b_en),
    .sel    (sel_ab),
    .live   (a_in),
    .stored (ab_q),
    .dout   (b_drive)
  );

  xcvr_path #(.W(W)) u_path_a (
    .en     (drv_a_en),
    .sel    (sel_ba),
    .live   (b_in),
    .stored (ba_q),
    .dout   (a_drive)
  );

  // The value actually present on each bus: own drive wins over the pins.
  assign bus_a_eff = drv_a_en ? a_drive : a_in;
  assign bus_b_eff = drv_b_en ? b_drive : b_in;

  xcvr_store_reg #(.W(W)) u_reg_ab (
    .clk   (clk_ab),
    .rst_n (rst_n),
    .d     (bus_a_eff),
    .q     (ab_q)
  );

  xcvr_store_reg #(.W(W)) u_reg_ba (
    .clk   (clk_ba),
    .rst_n (rst_n),
    .d     (bus_b_eff),
    .q     (ba_q)
  );

  assign a_out = a_drive;
  assign b_out = b_drive;
  assign a_oe  = drv_a_en;
  assign b_oe  = drv_b_en;
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         oe_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q,
  input logic [W-1:0] bus_a_eff,
  input logic [W-1:0] bus_b_eff
);
  // R6 / R7: the A-to-B register holds what bus A carried at its last edge
  p_capture_ab_r6: assert property (@(posedge clk_ab) disable iff (!rst_n)
    rst_n |=> ab_q == $past(bus_a_eff));

  p_capture_ba_r6: assert property (@(posedge clk_ba) disable iff (!rst_n)
    rst_n |=> ba_q == $past(bus_b_eff));

  p_one_bus_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !(a_oe && b_oe));

  p_one_bus_ba_r3: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !(a_oe && b_oe));

  p_isolate_r2: assert property (@(posedge clk_ba) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  p_live_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe && !sel_ab) |-> b_out == a_in);

  p_stored_r5: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_oe && sel_ba) |-> a_out == ba_q);
endmodule

bind regbus_xcvr xcvr_chk #(.W(W)) u_chk (
  .rst_n     (rst_n),
  .clk_ab    (clk_ab),
  .clk_ba    (clk_ba),
  .oe_n      (oe_n),
  .sel_ab    (sel_ab),
  .sel_ba    (sel_ba),
  .a_in      (a_in),
  .a_out     (a_out),
  .a_oe      (a_oe),
  .b_out     (b_out),
  .b_oe      (b_oe),
  .ab_q      (ab_q),
  .ba_q      (ba_q),
  .bus_a_eff (bus_a_eff),
  .bus_b_eff (bus_b_eff)
);

// File: tb/tb_regbus_xcvr.sv
module tb_regbus_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         rst_n, clk_ab, clk_ba, oe_n, dir_a2b, sel_ab, sel_ba;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [W-1:0] m_ab, m_ba;

  regbus_xcvr #(.W(W)) dut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n),
    .dir_a2b(dir_a2b), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  // Reference: arithmetic restatement of R2..R5
  function automatic logic [2*W+1:0] ref_outs();
    logic ea, eb;
    logic [W-1:0] va, vb;
    ea = (oe_n == 1'b0) && (dir_a2b == 1'b0);
    eb = (oe_n == 1'b0) && (dir_a2b == 1'b1);
    va = ea ? (sel_ba ? m_ba : b_in) : '0;
    vb = eb ? (sel_ab ? m_ab : a_in) : '0;
    return {ea, va, eb, vb};
  endfunction

  task automatic check_out(input string tag);
    logic [2*W+1:0] exp, act;
    exp = ref_outs();
    act = {a_oe, a_out, b_oe, b_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {a_oe,a_out,b_oe,b_out} actual=%h expected=%h (oe_n=%b dir=%b sab=%b sba=%b)",
               tag, act, exp, oe_n, dir_a2b, sel_ab, sel_ba);
    end
  endtask

  task automatic pulse_ab();
    clk_ab = 1'b1; #(CLK_PERIOD/2);
    clk_ab = 1'b0; #(CLK_PERIOD/2);
  endtask

  task automatic pulse_ba();
    clk_ba = 1'b1; #(CLK_PERIOD/2);
    clk_ba = 1'b0; #(CLK_PERIOD/2);
  endtask

  task automatic set_ctrl(input logic o, input logic d, input logic s1, input logic s2);
    oe_n = o; dir_a2b = d; sel_ab = s1; sel_ba = s2;
    #1;
  endtask

  // Bring both registers out through the outputs, then restore the controls
  task automatic read_regs(input string tag);
    logic o, d, s1, s2;
    o = oe_n; d = dir_a2b; s1 = sel_ab; s2 = sel_ba;
    set_ctrl(1'b0, 1'b1, 1'b1, s2);
    check_out(tag);
    set_ctrl(1'b0, 1'b0, s1, 1'b1);
    check_out(tag);
    set_ctrl(o, d, s1, s2);
  endtask

  // Effective bus values as the model sees them (R7 for a driven bus)
  function automatic logic [W-1:0] eff_a();
    logic [2*W+1:0] e;
    e = ref_outs();
    return e[2*W+1] ? e[2*W:W+1] : a_in;
  endfunction

  function automatic logic [W-1:0] eff_b();
    logic [2*W+1:0] e;
    e = ref_outs();
    return e[W] ? e[W-1:0] : b_in;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [6];
    logic [W-1:0] ea, eb;
    string mtag, ctag;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;

    rst_n = 1'b0; clk_ab = 0; clk_ba = 0;
    a_in = 8'hC3; b_in = 8'h3C;
    m_ab = '0; m_ba = '0;
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    // R1: edges during reset do not load
    pulse_ab(); pulse_ba();
    read_regs("R1");
    rst_n = 1'b1;
    #CLK_PERIOD;
    read_regs("R1");

    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 16; c++) begin
        a_in = pats[p];
        b_in = pats[p] ^ 8'h3C ^ W'(c);
        set_ctrl(c[3], c[2], c[1], c[0]);
        if (oe_n) mtag = "R2";
        else if ((dir_a2b ? sel_ab : sel_ba) == 1'b1) mtag = "R5";
        else mtag = "R4";
        check_out(mtag);
        check_out("R3");

        ea = eff_a();
        ctag = a_oe ? "R7" : "R6";
        pulse_ab(); m_ab = ea;
        check_out(ctag);
        read_regs(ctag);

        b_in = ~b_in;
        #1;
        eb = eff_b();
        ctag = b_oe ? "R7" : "R6";
        pulse_ba(); m_ba = eb;
        check_out(ctag);
        read_regs(ctag);
      end
    end

    // R8: one clock only, the other register must stay
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    a_in = 8'h11; b_in = 8'h22;
    #1;
    pulse_ab(); m_ab = 8'h11;
    pulse_ba(); m_ba = 8'h22;
    a_in = 8'h99; b_in = 8'h66;
    #1;
    pulse_ba(); m_ba = 8'h66;
    read_regs("R8");
    a_in = 8'h77;
    #1;
    pulse_ab(); m_ab = 8'h77;
    read_regs("R8");

    // R1: reset in mid-run clears stored data
    rst_n = 1'b0; #1;
    m_ab = '0; m_ba = '0;
    read_regs("R1");
    rst_n = 1'b1; #CLK_PERIOD;
    read_regs("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule